// File: doc/BRIEF.md
# SPI Register Access Frontend

This block is an SPI target that turns each chip-select framed transaction into byte accesses on a 16-bit byte-addressed register bus. A transaction opens with a header of two or three bytes that carries an address and a 3-bit command. The data phase that follows either streams register bytes out on MISO (read) or takes bytes from MOSI and writes them (write). The address steps up by one after every data byte. While the master shifts the header in, the block shifts the bytes of a 24-bit interrupt status word back out, one byte per header byte.

The SPI pins are sampled by the system clock through a synchronizer, and all logic runs in that clock domain. SPI mode 0 is used with the most significant bit first: MOSI is taken on the rising SCLK edge and MISO moves after the falling edge. A read is issued to the register bus ahead of the byte slot that needs it, so the byte is ready on MISO before that slot's first rising edge. The register bus returns read data in the cycle after the read strobe. The design assumes that SCLK stays in each level for at least eight system clocks, and that chip select falls at least four system clocks before the first SCLK rise.

Top module: `spi_reg_frontend`

## Requirements
- R1: During and after synchronous active-low reset, `reg_wr`, `reg_rd` and `spi_miso` are low.
- R2: Command code field values are 000 no operation, 010 read, 100 write and 110 header extension, and all other values are reserved. In the short header, the first byte gives address bits 12:5. The second byte gives address bits 4:0 in its bits 7:3 and the command in its bits 2:0. Address bits 15:13 are zero, and data starts at transfer byte 2.
- R3: A command of 110 in the second byte extends the header to a third byte. That byte's bits 7:5 give address bits 15:13, its bits 4:2 give the operative command, and its bits 1:0 are reserved and must be 00. Data starts at transfer byte 3.
- R4: On MISO, header byte 0 returns `irq_status[7:0]` and header byte 1 returns `irq_status[15:8]`. With a three-byte header, header byte 2 returns `irq_status[23:16]`. All bytes are sent most significant bit first.
- R5: For a write, each complete data byte k produces exactly one `reg_wr` pulse with `reg_addr` equal to the start address plus k (modulo 2^16) and `reg_wdata` equal to that byte.
- R6: For a read, data byte k on MISO is the register bus data for the start address plus k (modulo 2^16). A `reg_rd` pulse is issued for the start address at the end of the header, and another for the next address after each data byte.
- R7: A no-operation command, a reserved command, or nonzero reserved bits in the third header byte produce no `reg_wr` or `reg_rd` pulse, and MISO carries zeros in the data phase.
- R8: A data byte cut short by raising chip select produces no write. Raising chip select ends the transaction, and the next transaction decodes its header from byte 0.
- R9: `reg_wr` and `reg_rd` are single-cycle pulses and are never high together.
- R10: MISO is low while chip select has been deasserted for four or more system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| irq_status | input | 24 | Interrupt status returned during the header |
| reg_addr | output | 16 | Register bus byte address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Register bus write strobe, one cycle |
| reg_rd | output | 1 | Register bus read strobe, one cycle |
| reg_rdata | input | 8 | Register bus read data, valid the cycle after `reg_rd` |

## Verification
The bench goes after the header decode at its edges. In one case a short-header write starts at 0x1FFF and its address steps past the 8 KB limit. In another, an extended-header read starts at 0xFFFE and its address wraps to zero. A design that masked the stepped address or dropped the upper bits would write or read the wrong register. Reserved commands, a repeated extension code and nonzero reserved bits must stay silent on the bus and send zeros; a decoder that only looked at one command bit would start writing. A write cut off partway through its last byte must lose only that byte, and the transaction after it must decode cleanly; a design that did not reset on chip select would misalign every later header. The randomized transactions compare the returned status bytes against the status word for both header lengths.

// File: rtl/spi_reg_pkg.sv
// Shared constants, state types and the command decoder for the SPI
// register frontend. Assumes byte-wide data and a 16-bit address space.
package spi_reg_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int IRQ_BYTES = 3;
    localparam int IRQ_W     = IRQ_BYTES * BYTE_W;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    localparam logic [2:0] CODE_NOP = 3'b000;
    localparam logic [2:0] CODE_RD  = 3'b010;
    localparam logic [2:0] CODE_WR  = 3'b100;
    localparam logic [2:0] CODE_EXT = 3'b110;

    typedef enum logic [1:0] {PH_HDR0, PH_HDR1, PH_HDR2, PH_DATA} phase_e;
    typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;

    // Map a command code and the reserved bits to the bus operation.
    function automatic op_e decode_op(input logic [2:0] code, input logic [1:0] rsvd);
        op_e r;
        r = OP_IDLE;
        if (rsvd == 2'b00) begin
            if (code == CODE_RD) r = OP_READ;
            else if (code == CODE_WR) r = OP_WRITE;
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Brings SCLK, chip select and MOSI into the system clock domain through a
// chain of flops and reports SCLK edges as single-cycle pulses.
// Assumes SCLK holds each level for several system clocks.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sclk,
    input  logic pin_cs_n,
    input  logic pin_mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);
    // Bit order in each stage: {mosi, cs_n, sclk}
    localparam logic [2:0] IDLE_VAL = 3'b010;

    logic [2:0] stg [STAGES];
    logic       sclk_prev;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Each flop stage takes the pins or the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= IDLE_VAL;
                else if (gi == 0) stg[gi] <= {pin_mosi, pin_cs_n, pin_sclk};
                else stg[gi] <= stg[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    // Remember the last synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else sclk_prev <= stg[STAGES-1][0];
    end

    assign sclk_rise = stg[STAGES-1][0] & ~sclk_prev;
    assign sclk_fall = ~stg[STAGES-1][0] & sclk_prev;
    assign cs_active = ~stg[STAGES-1][1];
    assign mosi_s    = stg[STAGES-1][2];
endmodule

// File: rtl/spi_byte_shifter.sv
// Serial-to-byte and byte-to-serial shifter for SPI mode 0, MSB first.
// Loads the first outgoing byte when chip select becomes active, and at
// each later byte boundary loads the byte presented on next_byte.
// A byte that is not complete when chip select rises is discarded.
module spi_byte_shifter
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] first_byte,
    input  logic [BYTE_W-1:0] next_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    tx_sh;
    logic                 started;

    // Shift MOSI in on rising edges and MISO out on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt   <= '0;
            rx_byte   <= '0;
            tx_sh     <= '0;
            started   <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!started) begin
                tx_sh   <= first_byte;
                started <= 1'b1;
            end else if (sclk_rise) begin
                rx_byte   <= {rx_byte[BYTE_W-2:0], mosi_s};
                bit_cnt   <= bit_cnt + 1'b1;
                byte_done <= (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
            end else if (sclk_fall) begin
                if (bit_cnt == '0) tx_sh <= next_byte;
                else tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_reg_frontend.sv
// SPI target that decodes a 2- or 3-byte address/command header and then
// performs sequential byte reads or writes on a register bus, returning the
// interrupt status bytes on MISO during the header.
// Assumes reg_rdata is valid the cycle after reg_rd and that SCLK is slow
// against clk (at least eight clocks per level).
module spi_reg_frontend
    import spi_reg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [IRQ_W-1:0]  irq_status,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              sclk_rise, sclk_fall, cs_active, mosi_s;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] nxt_byte;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] hdr_addr;
    logic              rd_pend;
    phase_e            phase;
    op_e               op;
    op_e               hdr_op;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_sclk  (spi_sclk),
        .pin_cs_n  (spi_cs_n),
        .pin_mosi  (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_byte_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .mosi_s     (mosi_s),
        .first_byte (irq_status[BYTE_W-1:0]),
        .next_byte  (nxt_byte),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .miso       (spi_miso)
    );

    // Form the start address and operation of a header that ends with this byte.
    always_comb begin
        if (phase == PH_HDR2) begin
            hdr_addr = {rx_byte[7:5], cur_addr[12:0]};
            hdr_op   = decode_op(rx_byte[4:2], rx_byte[1:0]);
        end else begin
            hdr_addr = {3'b000, cur_addr[12:5], rx_byte[7:3]};
            hdr_op   = decode_op(rx_byte[2:0], 2'b00);
        end
    end

    // Header state machine, address stepping and register bus strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_HDR0;
            op        <= OP_IDLE;
            cur_addr  <= '0;
            nxt_byte  <= '0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            rd_pend   <= 1'b0;
        end else begin
            reg_wr  <= 1'b0;
            reg_rd  <= 1'b0;
            rd_pend <= reg_rd;
            if (rd_pend) nxt_byte <= reg_rdata;
            if (!cs_active) begin
                phase <= PH_HDR0;
                op    <= OP_IDLE;
            end else if (byte_done) begin
                case (phase)
                    PH_HDR0: begin
                        cur_addr <= {3'b000, rx_byte, 5'b00000};
                        nxt_byte <= irq_status[2*BYTE_W-1:BYTE_W];
                        phase    <= PH_HDR1;
                    end
                    PH_HDR1, PH_HDR2: begin
                        cur_addr <= hdr_addr;
                        if (phase == PH_HDR1 && rx_byte[2:0] == CODE_EXT) begin
                            nxt_byte <= irq_status[3*BYTE_W-1:2*BYTE_W];
                            phase    <= PH_HDR2;
                        end else begin
                            phase    <= PH_DATA;
                            op       <= hdr_op;
                            nxt_byte <= '0;
                            if (hdr_op == OP_READ) begin
                                reg_rd   <= 1'b1;
                                reg_addr <= hdr_addr;
                            end
                        end
                    end
                    default: begin
                        if (op == OP_WRITE) begin
                            reg_wr    <= 1'b1;
                            reg_addr  <= cur_addr;
                            reg_wdata <= rx_byte;
                            cur_addr  <= cur_addr + 1'b1;
                        end else if (op == OP_READ) begin
                            reg_rd   <= 1'b1;
                            reg_addr <= cur_addr + 1'b1;
                            cur_addr <= cur_addr + 1'b1;
                        end else begin
                            nxt_byte <= '0;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_reg_frontend_chk.sv
// Property checker for the SPI register frontend, attached by bind.
// Tracks the last strobed address per transaction to check address stepping.
module spi_reg_frontend_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        spi_miso,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [15:0] reg_addr
);
    logic        wr_seen, rd_seen;
    logic [15:0] last_wr, last_rd;

    // Record the previous strobed address inside one chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n || spi_cs_n) begin
            wr_seen <= 1'b0;
            rd_seen <= 1'b0;
            last_wr <= '0;
            last_rd <= '0;
        end else begin
            if (reg_wr) begin
                wr_seen <= 1'b1;
                last_wr <= reg_addr;
            end
            if (reg_rd) begin
                rd_seen <= 1'b1;
                last_rd <= reg_addr;
            end
        end
    end

    assert_strobe_mutex_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_rd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);

    assert_wr_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wr_seen) |-> (reg_addr == last_wr + 16'd1));

    assert_rd_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && rd_seen) |-> (reg_addr == last_rd + 16'd1));
endmodule

bind spi_reg_frontend spi_reg_frontend_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr)
);

// File: tb/test_spi_reg_frontend.sv
module test_spi_reg_frontend;
    localparam int HALF = 8;
    localparam logic [2:0] C_NOP = 3'b000, C_RD = 3'b010, C_WR = 3'b100, C_EXT = 3'b110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic        spi_miso;
    logic [23:0] irq_status = '0;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_rdata = '0;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0]  txb [32];
    logic [7:0]  rxb [32];
    logic [15:0] wr_a [32];
    logic [7:0]  wr_d [32];
    logic [15:0] rd_a [32];
    int wn = 0, rn = 0;

    always #2 clk = ~clk;

    spi_reg_frontend i_spi_reg_frontend (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq_status(irq_status),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] reg_val(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // Register bus model: data one cycle after the read strobe.
    always @(posedge clk) if (reg_rd) reg_rdata <= reg_val(reg_addr);

    // Bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && reg_wr && wn < 32) begin wr_a[wn] = reg_addr; wr_d[wn] = reg_wdata; wn++; end
        if (rst_n && reg_rd && rn < 32) begin rd_a[rn] = reg_addr; rn++; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    // Send nfull full bytes from txb, then tail bits of txb[nfull].
    task automatic xfer(input int nfull, input int tail);
        wn = 0; rn = 0;
        spi_cs_n = 1'b0;
        wait_half(); wait_half();
        for (int i = 0; i <= nfull; i++) begin
            int nb;
            nb = (i == nfull) ? tail : 8;
            rxb[i] = '0;
            for (int b = 0; b < nb; b++) begin
                spi_mosi = txb[i][7-b];
                wait_half();
                rxb[i] = {rxb[i][6:0], spi_miso};
                spi_sclk = 1'b1;
                wait_half();
                spi_sclk = 1'b0;
            end
        end
        wait_half();
        spi_cs_n = 1'b1;
        wait_half(); wait_half();
        chk(spi_miso == 1'b0, "R10 miso idle", spi_miso, 0);
    endtask

    // Build a header, run it, and check every requirement it touches.
    task automatic run_case(input bit ext, input logic [2:0] cmd, input logic [1:0] rsvd,
                            input logic [15:0] addr, input int nd, input int tail);
        int hl, nops;
        logic [15:0] ea;
        bit rd_op, wr_op;
        hl = ext ? 3 : 2;
        ea = ext ? addr : {3'b000, addr[12:0]};
        rd_op = (rsvd == 2'b00) && (cmd == C_RD);
        wr_op = (rsvd == 2'b00) && (cmd == C_WR);
        txb[0] = addr[12:5];
        txb[1] = {addr[4:0], ext ? C_EXT : cmd};
        txb[2] = {addr[15:13], cmd, rsvd};
        for (int k = hl; k < 32; k++) txb[k] = 8'($urandom);
        xfer(hl + nd, tail);
        chk(rxb[0] == irq_status[7:0], "R4 status byte0", rxb[0], irq_status[7:0]);
        chk(rxb[1] == irq_status[15:8], "R4 status byte1", rxb[1], irq_status[15:8]);
        if (ext) chk(rxb[2] == irq_status[23:16], "R4 status byte2", rxb[2], irq_status[23:16]);
        if (wr_op) begin
            chk(wn == nd && rn == 0, "R5/R8 write count", wn, nd);
            for (int k = 0; k < nd && k < wn; k++) begin
                chk(wr_a[k] == ea + 16'(k), ext ? "R3 R5 write addr" : "R2 R5 write addr",
                    wr_a[k], ea + 16'(k));
                chk(wr_d[k] == txb[hl+k], "R5 write data", wr_d[k], txb[hl+k]);
            end
        end else if (rd_op) begin
            chk(rn == nd + 1 && wn == 0, "R6 read count", rn, nd + 1);
            for (int k = 0; k < nd && k < rn; k++) begin
                chk(rd_a[k] == ea + 16'(k), ext ? "R3 R6 read addr" : "R2 R6 read addr",
                    rd_a[k], ea + 16'(k));
                chk(rxb[hl+k] == reg_val(ea + 16'(k)), "R6 read data",
                    rxb[hl+k], reg_val(ea + 16'(k)));
            end
        end else begin
            nops = wn + rn;
            chk(nops == 0, "R7 no access", nops, 0);
            for (int k = 0; k < nd; k++)
                chk(rxb[hl+k] == 8'h00, "R7 zero data", rxb[hl+k], 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        chk(!reg_wr && !reg_rd && !spi_miso, "R1 in reset", {reg_wr, reg_rd, spi_miso}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!reg_wr && !reg_rd && !spi_miso, "R1 after reset", {reg_wr, reg_rd, spi_miso}, 0);

        // Directed: short header write crossing 8 KB, extended read wrapping.
        irq_status = 24'h3C5A96;
        run_case(1'b0, C_WR, 2'b00, 16'h1FFF, 3, 0);
        irq_status = 24'hE1D2C3;
        run_case(1'b1, C_RD, 2'b00, 16'hFFFE, 3, 0);
        // Directed R7 cases: NOP, reserved codes, nonzero reserved bits.
        run_case(1'b0, C_NOP, 2'b00, 16'h0123, 2, 0);
        run_case(1'b0, 3'b001, 2'b00, 16'h0456, 2, 0);
        run_case(1'b1, C_WR, 2'b01, 16'hA5A5, 2, 0);
        run_case(1'b1, C_EXT, 2'b00, 16'h7777, 2, 0);
        run_case(1'b1, 3'b111, 2'b00, 16'h8888, 1, 0);
        // Directed R8: partial last byte, then a clean transaction.
        run_case(1'b1, C_WR, 2'b00, 16'hC000, 2, 5);
        run_case(1'b0, C_RD, 2'b00, 16'h0100, 2, 0);
        // Header cut after one byte, then a fresh write (R8).
        txb[0] = 8'hFF;
        xfer(1, 3);
        chk(wn == 0 && rn == 0, "R8 aborted header", wn + rn, 0);
        run_case(1'b0, C_WR, 2'b00, 16'h0042, 1, 0);

        // Randomized transactions.
        for (int t = 0; t < 30; t++) begin
            bit ext;
            logic [2:0] cmd;
            logic [1:0] rsvd;
            int sel;
            ext = 1'($urandom);
            sel = int'($urandom % 8);
            cmd = (sel < 3) ? C_RD : (sel < 6) ? C_WR : (sel == 6) ? C_NOP : 3'b101;
            rsvd = (ext && ($urandom % 6 == 0)) ? 2'b10 : 2'b00;
            irq_status = 24'($urandom);
            run_case(ext, cmd, rsvd, 16'($urandom), 1 + int'($urandom % 4),
                     (cmd == C_WR && $urandom % 4 == 0) ? 1 + int'($urandom % 7) : 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule